// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a CPU-side request path and a PCI bus master. It holds a small set of programmable outbound windows. Each window names a base and a size in the CPU local address space and a base in the 64-bit PCI address space. For each valid request the block reports whether the address lands in an enabled window. On a hit it also reports which window matched and the PCI address, which is the PCI base plus the offset of the request from the local base.

Software programs the windows through 32-bit registers on a simple register port. A write takes effect in the clock edge that samples it. Reads are combinational on the offset. Each window's size comes from the two's complement of its attribute word, whose bit 0 is the enable. A spare third attribute register is stored and reads back, but it never creates a mapping. The translation result is registered, so it appears one cycle after the request.

Top module: `obwin_xlate`

## Requirements
- R1: After reset every window register reads zero, and no request produces a hit.
- R2: Register offsets are 0x68/0x6C/0x70/0x74/0x78 for window 0 (local low, local high, attribute, PCI low, PCI high) and 0x7C/0x80/0x84/0x88/0x8C for window 1. A low half reads bits 31:0 of its 64-bit address and a high half reads bits 63:32.
- R3: Bit 0 of a window's attribute word enables it. A window whose enable is clear never hits.
- R4: The window size is the 32-bit two's complement of the attribute word with bit 0 forced to zero. A zero result is replaced by 0xFFFFFFFF.
- R5: Writing one half of a 64-bit address register leaves the other half unchanged.
- R6: A request hits a window when local base <= address < local base + size. The output PCI address is PCI base + (address - local base).
- R7: When several enabled windows match, the lowest-numbered one wins and its index is reported.
- R8: The spare attribute register at offset 0x90 stores and reads back any value, and no value written there ever causes a hit.
- R9: The outputs valid, hit, window index and PCI address appear one clock after a request is presented. With no request, or on a miss, hit, index and PCI address are all zero.
- R10: Offsets outside the decoded set read as zero, and writes to them change no register.
- R11: A request presented in the cycle after a register write is translated with the new register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_off | input | 8 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_off (combinational) |
| req_valid | input | 1 | CPU-side request present |
| req_addr | input | 64 | CPU local address of the request |
| out_valid | output | 1 | Registered request-valid |
| out_hit | output | 1 | Request matched an enabled window |
| out_win | output | 1 | Index of the matching window |
| out_pci_addr | output | 64 | Translated PCI address, zero on a miss |

## Verification
The main function is tried with one table of addresses against two overlapping windows of different sizes. The table includes the first and last byte of each window, the bytes just outside each end, an address whose low half matches but whose high half does not, and addresses in the overlap. Together these separate off-by-one errors in the inclusive base and the exclusive end, a compare that looks only at the low 32 bits, and a wrong priority order. Directed cases then disable a window, program an all-ones mask to reach the zero-size substitute, write the spare attribute register and undecoded offsets, and rewrite single address halves. These show whether the enable bit, the size decode, half preservation and write-to-use timing each behave as required.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned OFF_W  = 8;

  // register layout: windows packed at a fixed stride, one word per field
  localparam int unsigned WIN_BASE_OFF = 32'h68;
  localparam int unsigned WIN_STRIDE   = 32'h14;
  localparam int unsigned F_LCL_LO = 0;
  localparam int unsigned F_LCL_HI = 1;
  localparam int unsigned F_ATTR   = 2;
  localparam int unsigned F_PCI_LO = 3;
  localparam int unsigned F_PCI_HI = 4;
  localparam int unsigned NUM_FLD  = 5;

  typedef struct packed {
    logic [ADDR_W-1:0] lcl;
    logic [ADDR_W-1:0] pci;
    logic [REG_W-1:0]  attr;
  } win_cfg_t;

  function automatic logic [OFF_W-1:0] fld_off(input int unsigned w, input int unsigned f);
    return OFF_W'(WIN_BASE_OFF + w * WIN_STRIDE + f * 4);
  endfunction

  // span of a window from its attribute word
  function automatic logic [REG_W-1:0] win_size(input logic [REG_W-1:0] attr);
    logic [REG_W-1:0] s;
    s = ~(attr & ~REG_W'(1)) + REG_W'(1);
    if (s == '0) s = '1;
    return s;
  endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_MAP = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OFF_W-1:0]      reg_off,
  input  logic                  reg_wen,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output win_cfg_t [NUM_MAP-1:0] cfg_o
);

  localparam logic [OFF_W-1:0] SPARE_OFF = fld_off(NUM_MAP, 0);
  localparam logic [OFF_W-1:0] LO_END    = OFF_W'(WIN_BASE_OFF);

  win_cfg_t [NUM_MAP-1:0] cfg_q, cfg_d;
  logic [REG_W-1:0]       spare_q, spare_d;
  logic                   spare_hit;

  // next-state
  always_comb begin
    cfg_d   = cfg_q;
    spare_d = spare_q;
    for (int w = 0; w < NUM_MAP; w++) begin
      if (reg_off == fld_off(w, F_LCL_LO)) cfg_d[w].lcl[REG_W-1:0]      = reg_wdata;
      if (reg_off == fld_off(w, F_LCL_HI)) cfg_d[w].lcl[ADDR_W-1:REG_W] = reg_wdata;
      if (reg_off == fld_off(w, F_ATTR))   cfg_d[w].attr                = reg_wdata;
      if (reg_off == fld_off(w, F_PCI_LO)) cfg_d[w].pci[REG_W-1:0]      = reg_wdata;
      if (reg_off == fld_off(w, F_PCI_HI)) cfg_d[w].pci[ADDR_W-1:REG_W] = reg_wdata;
    end
    spare_hit = (reg_off == SPARE_OFF);
    if (spare_hit) spare_d = reg_wdata;
  end

  // storage, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      spare_q <= '0;
    end else if (reg_wen) begin
      cfg_q   <= cfg_d;
      spare_q <= spare_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NUM_MAP; w++) begin
      if (reg_off == fld_off(w, F_LCL_LO)) reg_rdata = cfg_q[w].lcl[REG_W-1:0];
      if (reg_off == fld_off(w, F_LCL_HI)) reg_rdata = cfg_q[w].lcl[ADDR_W-1:REG_W];
      if (reg_off == fld_off(w, F_ATTR))   reg_rdata = cfg_q[w].attr;
      if (reg_off == fld_off(w, F_PCI_LO)) reg_rdata = cfg_q[w].pci[REG_W-1:0];
      if (reg_off == fld_off(w, F_PCI_HI)) reg_rdata = cfg_q[w].pci[ADDR_W-1:REG_W];
    end
    if (reg_off == SPARE_OFF) reg_rdata = spare_q;
  end

  assign cfg_o = cfg_q;

  // R5: a low-half write leaves the high half alone
  a_r5_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_off == fld_off(0, F_LCL_LO)) |=>
      cfg_q[0].lcl[ADDR_W-1:REG_W] == $past(cfg_q[0].lcl[ADDR_W-1:REG_W]));

  // R10: writes outside the decoded span touch nothing
  a_r10_undecoded_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && (reg_off < LO_END || reg_off > SPARE_OFF || reg_off[1:0] != 2'b00)) |=>
      ($stable(cfg_q) && $stable(spare_q)));

endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat
);

  logic [REG_W-1:0]  span;
  logic [ADDR_W-1:0] offs;
  logic              above;

  always_comb begin
    span  = win_size(cfg.attr);
    offs  = addr - cfg.lcl;
    above = (addr >= cfg.lcl);
    hit   = cfg.attr[0] && above && (offs < {{(ADDR_W-REG_W){1'b0}}, span});
    xlat  = cfg.pci + offs;
  end

endmodule

// File: rtl/obwin_pick.sv
module obwin_pick
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_MAP = 2,
  localparam int unsigned WIN_W = (NUM_MAP > 1) ? $clog2(NUM_MAP) : 1
) (
  input  logic [NUM_MAP-1:0]             hit_vec,
  input  logic [NUM_MAP-1:0][ADDR_W-1:0] xlat_vec,
  output logic                           any_hit,
  output logic [WIN_W-1:0]               win_idx,
  output logic [ADDR_W-1:0]              pci_addr
);

  // scan downward so the lowest index is the last to assign
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    pci_addr = '0;
    for (int w = NUM_MAP - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        any_hit  = 1'b1;
        win_idx  = WIN_W'(w);
        pci_addr = xlat_vec[w];
      end
    end
  end

endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int unsigned NUM_MAP = 2,
  localparam int unsigned WIN_W = (NUM_MAP > 1) ? $clog2(NUM_MAP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_off,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              out_valid,
  output logic              out_hit,
  output logic [WIN_W-1:0]  out_win,
  output logic [63:0]       out_pci_addr
);

  // reset: asserted at once, released through two flops
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  win_cfg_t [NUM_MAP-1:0]         cfg;
  logic [NUM_MAP-1:0]             hit_vec;
  logic [NUM_MAP-1:0]             en_vec;
  logic [NUM_MAP-1:0][ADDR_W-1:0] xlat_vec;
  logic                           any_hit;
  logic [WIN_W-1:0]               pick_idx;
  logic [ADDR_W-1:0]              pick_addr;

  obwin_regs #(.NUM_MAP(NUM_MAP)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_off   (reg_off),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg_o     (cfg)
  );

  for (genvar w = 0; w < NUM_MAP; w++) begin : g_win
    obwin_match i_match (
      .cfg  (cfg[w]),
      .addr (req_addr),
      .hit  (hit_vec[w]),
      .xlat (xlat_vec[w])
    );
    assign en_vec[w] = cfg[w].attr[0];
  end

  obwin_pick #(.NUM_MAP(NUM_MAP)) i_pick (
    .hit_vec  (hit_vec),
    .xlat_vec (xlat_vec),
    .any_hit  (any_hit),
    .win_idx  (pick_idx),
    .pci_addr (pick_addr)
  );

  // output stage
  logic              vld_d, hit_d;
  logic [WIN_W-1:0]  win_d;
  logic [ADDR_W-1:0] pci_d;

  always_comb begin
    vld_d = req_valid;
    hit_d = req_valid && any_hit;
    win_d = hit_d ? pick_idx  : '0;
    pci_d = hit_d ? pick_addr : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      out_hit      <= 1'b0;
      out_win      <= '0;
      out_pci_addr <= '0;
    end else begin
      out_valid    <= vld_d;
      out_hit      <= hit_d;
      out_win      <= win_d;
      out_pci_addr <= pci_d;
    end
  end

  // R9: one-cycle latency on valid
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> out_valid);

  // R9: a miss carries no address or index
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_hit |-> (out_pci_addr == '0 && out_win == '0));

  // R3: a hit needs some window enabled in the sampling cycle
  a_r3_enable_needed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(out_hit) |-> $past(en_vec) != '0);

  // R9: no hit without a request
  a_r9_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_hit |-> out_valid);

endmodule

// File: tb/test_obwin_xlate.sv
`timescale 1ns/1ps
module test_obwin_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_off = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        out_valid, out_hit;
  logic [0:0]  out_win;
  logic [63:0] out_pci_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  obwin_xlate i_obwin_xlate (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_win(out_win), .out_pci_addr(out_pci_addr)
  );

  // {address, expect hit, expect window, expect pci address}
  localparam int NV = 8;
  localparam logic [129:0] VEC [NV] = '{
    {64'h0000_0001_8000_0000, 1'b1, 1'b0, 64'h0000_0000_C000_0000},
    {64'h0000_0001_8000_FFFF, 1'b1, 1'b0, 64'h0000_0000_C000_FFFF},
    {64'h0000_0001_8001_0000, 1'b1, 1'b1, 64'h0000_0002_0000_8000},
    {64'h0000_0001_7FFF_FFFF, 1'b0, 1'b0, 64'h0},
    {64'h0000_0001_8010_7FFF, 1'b1, 1'b1, 64'h0000_0002_000F_FFFF},
    {64'h0000_0001_8010_8000, 1'b0, 1'b0, 64'h0},
    {64'h0000_0000_8000_0000, 1'b0, 1'b0, 64'h0},
    {64'h0000_0001_8000_8000, 1'b1, 1'b0, 64'h0000_0000_C000_8000}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_off = off; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_off = off;
    #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  // request, sampled at the following falling edge (one register stage)
  task automatic req_chk(input logic [63:0] a, input bit eh, input bit ew,
                         input logic [63:0] ep, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
    chk(out_hit === eh, {tag, " hit"}, 64'(out_hit), 64'(eh));
    chk(out_win === ew, {tag, " win"}, 64'(out_win), 64'(ew));
    chk(out_pci_addr === ep, {tag, " pci"}, out_pci_addr, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int w = 0; w < 2; w++)
      for (int f = 0; f < 5; f++)
        rd_chk(8'(8'h68 + w * 20 + f * 4), 32'h0, "R1 reset read");
    rd_chk(8'h90, 32'h0, "R1 reset spare");
    req_chk(64'h0, 1'b0, 1'b0, 64'h0, "R1 no hit after reset");
    @(negedge clk);
    chk(out_valid === 1'b0 && out_hit === 1'b0, "R9 idle outputs", 64'({out_valid, out_hit}), 64'h0);

    // program: w0 local 1_8000_0000 size 64K -> pci C000_0000; w1 local 1_8000_8000 size 1M -> 2_0000_0000
    wr(8'h68, 32'h8000_0000); wr(8'h6C, 32'h1);
    wr(8'h74, 32'hC000_0000); wr(8'h78, 32'h0);
    wr(8'h70, 32'hFFFF_0001);
    wr(8'h7C, 32'h8000_8000); wr(8'h80, 32'h1);
    wr(8'h88, 32'h0);         wr(8'h8C, 32'h2);
    wr(8'h84, 32'hFFF0_0001);

    // R2: readback halves
    rd_chk(8'h68, 32'h8000_0000, "R2 w0 local lo");
    rd_chk(8'h6C, 32'h1, "R2 w0 local hi");
    rd_chk(8'h8C, 32'h2, "R2 w1 pci hi");
    rd_chk(8'h84, 32'hFFF0_0001, "R2 w1 attr");

    // R6 / R7 / R4: table walk
    for (int i = 0; i < NV; i++)
      req_chk(VEC[i][129:66], VEC[i][65], VEC[i][64], VEC[i][63:0], "R6 R7 R4 table");

    // R5: half writes keep the other half
    wr(8'h6C, 32'h0000_0003);
    rd_chk(8'h68, 32'h8000_0000, "R5 lo kept");
    rd_chk(8'h6C, 32'h3, "R5 hi new");
    wr(8'h6C, 32'h1);

    // R3 + R11: disable w0; next-cycle request sees it
    wr(8'h70, 32'hFFFF_0000);
    req_chk(64'h0000_0001_8000_0000, 1'b0, 1'b0, 64'h0, "R3 R11 disabled w0 miss");
    req_chk(64'h0000_0001_8000_8000, 1'b1, 1'b1, 64'h0000_0002_0000_0000, "R3 w1 takes overlap");

    // R4: zero-size substitute
    wr(8'h84, 32'h0);
    wr(8'h68, 32'h0); wr(8'h6C, 32'h0);
    wr(8'h74, 32'h10);
    wr(8'h70, 32'h0000_0001);
    req_chk(64'h0000_0000_FFFF_FFFE, 1'b1, 1'b0, 64'h0000_0001_0000_000E, "R4 near-4G last");
    req_chk(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 64'h0, "R4 near-4G end");

    // R8: spare attribute stores, never maps
    wr(8'h70, 32'h0);
    wr(8'h90, 32'h0000_0001);
    rd_chk(8'h90, 32'h0000_0001, "R8 spare readback");
    req_chk(64'h0, 1'b0, 1'b0, 64'h0, "R8 spare no map at 0");
    req_chk(64'h0000_0000_8000_0000, 1'b0, 1'b0, 64'h0, "R8 spare no map mid");

    // R10: undecoded offsets
    wr(8'h94, 32'hDEAD_BEEF);
    rd_chk(8'h94, 32'h0, "R10 undecoded reads zero");
    wr(8'h69, 32'h1234_5678);
    rd_chk(8'h68, 32'h0, "R10 misaligned write ignored");
    rd_chk(8'h90, 32'h1, "R10 spare untouched");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule